// File: doc/BRIEF.md
# Packet-Driven Control Sequencer

This block is the top-level state sequencer of a network-attached slow-control endpoint. Only one of its functional units is in charge at any moment: hard reset, soft reset, idle, packet reader, sensor querier, DAC programmer or packet transmitter. The sequencer keeps a 3-bit state, raises the enable line of the unit that owns the current state, and waits. It moves on only when that unit reports completion with a one-cycle done pulse. In idle, it moves on when the receive FIFO reports that it holds data.

Each unit is a done-strobe handshake. The reader gives its decoded verdict on the incoming packet at the same moment as its done pulse. That verdict selects the next unit: query, DAC program, one of the two resets, or reject. A single transmit unit serves both reply kinds. The middle state bit tells it whether to send a status reply or a DAC readback reply. Every reset ends in a status reply. A rejected packet returns to idle and sends nothing.

Top module: `pkt_ctrl_sequencer`

## Requirements
- R1: An active-low asynchronous reset forces the state (`stateOut`) to 3'b000, hard reset, without waiting for a clock edge, and `hardRstEn` is high while reset is held.
- R2: In every cycle exactly one of the seven enable outputs is high. The owners are: 000 hard reset, 001 soft reset, 010 idle, 011 reader, 100 querier, 110 DAC programmer, and 101 or 111 transmitter.
- R3: In a state that has not received its advance condition, the state and its enable stay unchanged at the next clock edge.
- R4: In idle (010), a high `rxNotEmpty` at a clock edge moves the state to reader (011).
- R5: In reader (011), a `readerDone` pulse moves the state according to `verdict`: 3'd0 query goes to 100, 3'd1 program goes to 110, 3'd2 hard reset goes to 000, and 3'd3 soft reset goes to 001.
- R6: In reader (011), a `readerDone` pulse with `verdict` 3'd4 (reject) or any undefined code from 3'd5 to 3'd7 returns the state to idle (010). No transmit state is entered.
- R7: A done pulse from hard reset (000) or soft reset (001) moves the state to status transmit (101).
- R8: A done pulse from the querier (100) moves the state to 101. A done pulse from the DAC programmer (110) moves the state to DAC transmit (111).
- R9: `txSelDac` is 1 in state 111 and 0 in every other state. In either transmit state (101 or 111), a `txDone` pulse returns the state to idle (010).
- R10: Done pulses from units that do not own the current state, and `rxNotEmpty` outside idle, have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxNotEmpty | input | 1 | Receive FIFO holds data |
| hardRstDone | input | 1 | Hard reset unit finished (one-cycle pulse) |
| softRstDone | input | 1 | Soft reset unit finished |
| readerDone | input | 1 | Reader finished; verdict valid |
| querierDone | input | 1 | Querier finished |
| programmerDone | input | 1 | DAC programmer finished |
| txDone | input | 1 | Transmitter finished |
| verdict | input | 3 | Reader decision: 0 query, 1 program, 2 hard reset, 3 soft reset, 4 to 7 reject |
| hardRstEn | output | 1 | Hard reset unit enable |
| softRstEn | output | 1 | Soft reset unit enable |
| idleEn | output | 1 | Idle unit enable |
| readerEn | output | 1 | Reader enable |
| querierEn | output | 1 | Querier enable |
| programmerEn | output | 1 | DAC programmer enable |
| txEn | output | 1 | Transmitter enable |
| txSelDac | output | 1 | Reply type: 1 DAC readback, 0 status |
| stateOut | output | 3 | Current state encoding |

## Verification
The assertions assume that every input is a known value and is stable around the sampling edge. They also assume that `verdict` matters only in a cycle where `readerDone` is high in the reader state, so undefined verdict codes are treated as rejects rather than excluded. The stimulus drives every input only at the falling edge. It pulses done lines, including those of units that do not own the state, and it sweeps all eight verdict codes. This keeps the inputs within those assumptions while still exercising the rule that foreign strobes are ignored. One asynchronous reset is applied in the middle of a cycle during the run.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int STATE_W   = 3;
  localparam int VERDICT_W = 3;
  localparam int NUM_UNITS = 7;

  // Unit index of each enable line
  localparam int U_HARD  = 0;
  localparam int U_SOFT  = 1;
  localparam int U_IDLE  = 2;
  localparam int U_READ  = 3;
  localparam int U_QUERY = 4;
  localparam int U_PROG  = 5;
  localparam int U_TX    = 6;

  typedef enum logic [STATE_W-1:0] {
    ST_HARD  = 3'b000,
    ST_SOFT  = 3'b001,
    ST_IDLE  = 3'b010,
    ST_READ  = 3'b011,
    ST_QUERY = 3'b100,
    ST_TXS   = 3'b101,
    ST_PROG  = 3'b110,
    ST_TXD   = 3'b111
  } seqState_t;

  localparam logic [VERDICT_W-1:0] V_QUERY = 3'd0;
  localparam logic [VERDICT_W-1:0] V_PROG  = 3'd1;
  localparam logic [VERDICT_W-1:0] V_HARD  = 3'd2;
  localparam logic [VERDICT_W-1:0] V_SOFT  = 3'd3;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic      load;
    seqState_t target;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqState_t            curState,
  input  logic                 rxNotEmpty,
  input  logic                 hardRstDone,
  input  logic                 softRstDone,
  input  logic                 readerDone,
  input  logic                 querierDone,
  input  logic                 programmerDone,
  input  logic                 txDone,
  input  logic [VERDICT_W-1:0] verdict,
  output seqStrobe_t           strobe
);

  seqState_t dispatch;

  // Reader verdict decode; anything unknown is a reject
  always_comb begin
    case (verdict)
      V_QUERY: dispatch = ST_QUERY;
      V_PROG:  dispatch = ST_PROG;
      V_HARD:  dispatch = ST_HARD;
      V_SOFT:  dispatch = ST_SOFT;
      default: dispatch = ST_IDLE;
    endcase
  end

  // Only the owning unit's strobe is looked at
  always_comb begin
    strobe.load   = 1'b0;
    strobe.target = curState;
    case (curState)
      ST_HARD: if (hardRstDone) begin
        strobe.load = 1'b1; strobe.target = ST_TXS;
      end
      ST_SOFT: if (softRstDone) begin
        strobe.load = 1'b1; strobe.target = ST_TXS;
      end
      ST_IDLE: if (rxNotEmpty) begin
        strobe.load = 1'b1; strobe.target = ST_READ;
      end
      ST_READ: if (readerDone) begin
        strobe.load = 1'b1; strobe.target = dispatch;
      end
      ST_QUERY: if (querierDone) begin
        strobe.load = 1'b1; strobe.target = ST_TXS;
      end
      ST_PROG: if (programmerDone) begin
        strobe.load = 1'b1; strobe.target = ST_TXD;
      end
      ST_TXS, ST_TXD: if (txDone) begin
        strobe.load = 1'b1; strobe.target = ST_IDLE;
      end
      default: strobe.load = 1'b0;
    endcase
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && !rxNotEmpty) |=> curState == ST_IDLE);

  assert_hold_prog_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_PROG && !programmerDone) |=> curState == ST_PROG);

  assert_idle_to_reader_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && rxNotEmpty) |=> curState == ST_READ);

  assert_query_dispatch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_READ && readerDone && verdict == V_QUERY) |=> curState == ST_QUERY);

  assert_prog_dispatch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_READ && readerDone && verdict == V_PROG) |=> curState == ST_PROG);

  assert_reset_dispatch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_READ && readerDone && verdict == V_SOFT) |=> curState == ST_SOFT);

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_READ && readerDone && verdict[2]) |=> curState == ST_IDLE);

  assert_reset_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_HARD && hardRstDone) || (curState == ST_SOFT && softRstDone))
      |=> curState == ST_TXS);

  assert_query_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_QUERY && querierDone) |=> curState == ST_TXS);

  assert_prog_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_PROG && programmerDone) |=> curState == ST_TXD);

  assert_tx_return_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_TXS || curState == ST_TXD) && txDone) |=> curState == ST_IDLE);

  assert_foreign_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_QUERY && !querierDone) |=> $stable(curState));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  output seqState_t            curState,
  output logic [NUM_UNITS-1:0] unitEn,
  output logic                 txSelDac
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            curState <= ST_HARD;
    else if (strobe.load) curState <= strobe.target;
  end

  // Owning unit of a state; bit 1 is ignored when bits 2 and 0 are both set
  function automatic int ownerOf(input seqState_t s);
    if (s[2] && s[0]) return U_TX;
    case (s)
      ST_HARD:  return U_HARD;
      ST_SOFT:  return U_SOFT;
      ST_IDLE:  return U_IDLE;
      ST_READ:  return U_READ;
      ST_QUERY: return U_QUERY;
      default:  return U_PROG;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_en
    assign unitEn[g] = (ownerOf(curState) == g);
  end

  assign txSelDac = unitEn[U_TX] & curState[1];

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(unitEn) == 1);

  assert_load_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> curState == $past(strobe.target));

endmodule

// File: rtl/pkt_ctrl_sequencer.sv
module pkt_ctrl_sequencer
  import seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxNotEmpty,
  input  logic                 hardRstDone,
  input  logic                 softRstDone,
  input  logic                 readerDone,
  input  logic                 querierDone,
  input  logic                 programmerDone,
  input  logic                 txDone,
  input  logic [VERDICT_W-1:0] verdict,
  output logic                 hardRstEn,
  output logic                 softRstEn,
  output logic                 idleEn,
  output logic                 readerEn,
  output logic                 querierEn,
  output logic                 programmerEn,
  output logic                 txEn,
  output logic                 txSelDac,
  output logic [STATE_W-1:0]   stateOut
);

  seqState_t            curState;
  seqStrobe_t           strobe;
  logic [NUM_UNITS-1:0] unitEn;

  seq_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .curState       (curState),
    .rxNotEmpty     (rxNotEmpty),
    .hardRstDone    (hardRstDone),
    .softRstDone    (softRstDone),
    .readerDone     (readerDone),
    .querierDone    (querierDone),
    .programmerDone (programmerDone),
    .txDone         (txDone),
    .verdict        (verdict),
    .strobe         (strobe)
  );

  seq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curState (curState),
    .unitEn   (unitEn),
    .txSelDac (txSelDac)
  );

  assign hardRstEn    = unitEn[U_HARD];
  assign softRstEn    = unitEn[U_SOFT];
  assign idleEn       = unitEn[U_IDLE];
  assign readerEn     = unitEn[U_READ];
  assign querierEn    = unitEn[U_QUERY];
  assign programmerEn = unitEn[U_PROG];
  assign txEn         = unitEn[U_TX];
  assign stateOut     = curState;

endmodule

// File: tb/pkt_ctrl_sequencer_bench.sv
`timescale 1ns/1ps
module pkt_ctrl_sequencer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxNotEmpty = 1'b0;
  logic [5:0] dn = '0;  // 0 hard,1 soft,2 read,3 query,4 prog,5 tx
  logic [2:0] verdict = '0;
  logic       hardRstEn, softRstEn, idleEn, readerEn, querierEn, programmerEn, txEn;
  logic       txSelDac;
  logic [2:0] stateOut;

  int testsRun = 0;
  int testsFailed = 0;
  int model = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  pkt_ctrl_sequencer u_pkt_ctrl_sequencer (
    .clk(clk), .rstN(rstN), .rxNotEmpty(rxNotEmpty),
    .hardRstDone(dn[0]), .softRstDone(dn[1]), .readerDone(dn[2]),
    .querierDone(dn[3]), .programmerDone(dn[4]), .txDone(dn[5]),
    .verdict(verdict),
    .hardRstEn(hardRstEn), .softRstEn(softRstEn), .idleEn(idleEn),
    .readerEn(readerEn), .querierEn(querierEn), .programmerEn(programmerEn),
    .txEn(txEn), .txSelDac(txSelDac), .stateOut(stateOut)
  );

  function automatic int nextOf(int s, bit rx, bit [5:0] d, int v);
    case (s)
      0: return d[0] ? 5 : 0;
      1: return d[1] ? 5 : 1;
      2: return rx ? 3 : 2;
      3: begin
        if (!d[2]) return 3;
        if (v == 0) return 4;
        if (v == 1) return 6;
        if (v == 2) return 0;
        if (v == 3) return 1;
        return 2;
      end
      4: return d[3] ? 5 : 4;
      6: return d[4] ? 7 : 6;
      default: return d[5] ? 2 : s;
    endcase
  endfunction

  function automatic logic [6:0] expEn(int s);
    case (s)
      0: return 7'b0000001;
      1: return 7'b0000010;
      2: return 7'b0000100;
      3: return 7'b0001000;
      4: return 7'b0010000;
      6: return 7'b0100000;
      default: return 7'b1000000;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [6:0] en;
    en = {txEn, programmerEn, querierEn, readerEn, idleEn, softRstEn, hardRstEn};
    check(tag, int'(stateOut), model, "state");
    check("R2", int'(en), int'(expEn(model)), "enables");
    check("R9", int'(txSelDac), (model == 7) ? 1 : 0, "txSelDac");
  endtask

  // One cycle: compare at falling edge, drive, advance model past rising edge
  task automatic step(string tag, bit rx, bit [5:0] d, int v);
    int nxt;
    @(negedge clk);
    compareAll(tag);
    rxNotEmpty = rx;
    dn = d;
    verdict = 3'(v);
    nxt = nextOf(model, rx, d, v);
    @(posedge clk);
    #1 model = nxt;
  endtask

  task automatic finishStep(string tag);
    @(negedge clk);
    compareAll(tag);
    rxNotEmpty = 0; dn = '0;
  endtask

  initial begin
    #30;
    // R1: asynchronous reset state
    check("R1", int'(stateOut), 0, "reset state");
    check("R1", int'(hardRstEn), 1, "hardRstEn in reset");
    @(negedge clk);
    rstN = 1'b1;
    step("R3", 0, 6'b000000, 0);                 // held in hard reset
    step("R10", 1, 6'b111110, 0);                // foreign strobes ignored
    step("R7", 0, 6'b000001, 0);                 // hard done -> 101
    step("R9", 0, 6'b000000, 0);
    step("R9", 0, 6'b100000, 0);                 // tx done -> idle
    step("R3", 0, 6'b111111, 0);                 // idle without rx holds
    step("R4", 1, 6'b000000, 0);                 // -> reader
    step("R5", 0, 6'b000100, 1);                 // program -> 110
    step("R10", 1, 6'b101111, 0);                // foreign strobes in 110
    step("R8", 0, 6'b010000, 0);                 // -> 111
    step("R9", 0, 6'b100000, 0);                 // DAC reply -> idle
    step("R4", 1, 6'b000000, 0);
    step("R5", 0, 6'b000100, 0);                 // query -> 100
    step("R8", 0, 6'b001000, 0);                 // -> 101
    step("R9", 0, 6'b100000, 0);
    step("R4", 1, 6'b000000, 0);
    step("R5", 0, 6'b000100, 3);                 // soft reset -> 001
    step("R7", 0, 6'b000010, 0);                 // -> 101
    step("R9", 0, 6'b100000, 0);
    for (int v = 4; v < 8; v++) begin
      step("R4", 1, 6'b000000, 0);
      step("R6", 0, 6'b000100, v);               // reject and undefined -> idle
    end
    step("R4", 1, 6'b000000, 0);
    step("R5", 0, 6'b000100, 2);                 // hard reset -> 000
    finishStep("R5");
    // Random phase: all strobes, all verdicts (R3, R10)
    for (int i = 0; i < 3000; i++) begin
      bit [5:0] d;
      for (int b = 0; b < 6; b++) d[b] = ($urandom % 4) == 0;
      step("R10", ($urandom % 3) == 0, d, int'($urandom % 8));
    end
    // R1: reset in the middle of a cycle acts at once
    @(negedge clk);
    rxNotEmpty = 0; dn = '0;
    #2 rstN = 1'b0;
    #1;
    check("R1", int'(stateOut), 0, "async reset state");
    check("R1", int'(hardRstEn), 1, "hardRstEn after async reset");
    model = 0;
    @(negedge clk);
    rstN = 1'b1;
    step("R1", 0, 6'b000000, 0);
    finishStep("R3");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule